// File: doc/BRIEF.md
# CRC Instruction Execution Unit

This unit runs the CRC step instructions of a core: eight register-to-register operations, each of which takes one source operand and produces one destination value. The instruction word is decoded inside the unit. A set of bits in it chooses one of two reflected polynomials, CRC-32 (0xEDB88320) or CRC-32C (0x82F63B78), and how many low-order bytes to fold in: 1, 2, 4 or 8. The operand enters the shift register unchanged. There is no preset, and the result is not inverted. Each byte step shifts the whole register right by eight, so the upper operand bits move down and are folded in by the later steps.

The core presents an instruction word, the source value and a 64-bit mode flag, then pulses `start_i`. While `busy_o` is high the unit folds one byte per clock. It then pulses `done_o` for one cycle with the result and the destination register index. A word that is not one of the eight operations gives a one-cycle `illegal_o` pulse in place of the work. So does a doubleword form issued outside 64-bit mode.

Top module: `crcx_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:25] = 0110000, bits [14:12] = 001 and bits [6:0] = 0010011; any other word is illegal.
- R2: The selector field in bits [24:20] must be of the form 1p0ss, where p=0 selects CRC-32 and p=1 selects CRC-32C, and ss = 00/01/10/11 selects 1/2/4/8 bytes. Every other selector value is illegal.
- R3: A CRC-32 byte step replaces x with T(x[7:0]) XOR (x >> 8), where T is the reflected table for polynomial 0xEDB88320.
- R4: A CRC-32C byte step uses the same rule with the reflected polynomial 0x82F63B78.
- R5: The unit folds exactly 1, 2, 4 or 8 bytes, one per clock, and `done_o` rises N clock edges after the edge that accepts the start.
- R6: The operand is used with no preset and no output inversion. The right shift is logical over the full register width, so the bits above the processed bytes feed the later steps.
- R7: A doubleword selector (10011 or 11011) is illegal when `mode64_i` is low or XLEN is 32. It raises `illegal_o` and produces no `done_o`.
- R8: When `mode64_i` is low, only the low 32 operand bits take part, zeros shift in above bit 31, and the upper result bits read zero.
- R9: `busy_o` is high from the cycle after an accepted start until the final step. `done_o` lasts one cycle and comes with `result_o` and `rd_idx_o` (bits [11:7] of the word).
- R10: A start that arrives while `busy_o` is high is ignored. The running result, the destination index and `illegal_o` are unaffected.
- R11: An illegal start gives `illegal_o` high for exactly the cycle after the accepting edge, with `busy_o` and `done_o` low.
- R12: Starting from 0x34e24a2cd65650d4 in 64-bit mode, the four CRC-32 forms (byte to doubleword), then the four CRC-32C forms, each fed the previous result, give 0x68167e78.
- R13: Under synchronous reset, `busy_o`, `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Issue strobe for the presented instruction |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Source operand value |
| mode64_i | input | 1 | High when the core runs in 64-bit mode |
| busy_o | output | 1 | A CRC is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | One-cycle illegal-instruction strobe |
| rd_idx_o | output | 5 | Destination register index, valid with done |
| result_o | output | XLEN | CRC result, valid with done |

## Verification
A bad byte counter shows at the ports as `done_o` arriving early or late against the selector size, in the same operation. A wrong polynomial or shift path gives a result mismatch at that operation's `done_o`. The eight-step chain then carries any such error into its final value. A decode state that wrongly keeps or drops a start shows within one cycle: as a spurious or missing `illegal_o`, as a `busy_o` edge, or as a later `rd_idx_o` that does not match.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    localparam logic [6:0] CRCX_OPCODE = 7'b0010011;
    localparam logic [6:0] CRCX_FUNCT7 = 7'b0110000;
    localparam logic [2:0] CRCX_FUNCT3 = 3'b001;

    localparam logic [31:0] CRCX_POLY_IEEE = 32'hEDB8_8320;
    localparam logic [31:0] CRCX_POLY_CAST = 32'h82F6_3B78;

    localparam int CRCX_CNT_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } crcx_size_e;

    typedef enum logic {
        POLY_IEEE = 1'b0,
        POLY_CAST = 1'b1
    } crcx_poly_e;

    typedef struct packed {
        logic       legal;
        crcx_poly_e poly;
        crcx_size_e size;
        logic [4:0] rd;
    } crcx_op_t;

    function automatic logic [CRCX_CNT_W-1:0] crcx_steps(crcx_size_e s);
        return CRCX_CNT_W'(1) << s;
    endfunction

    function automatic logic [31:0] crcx_poly_value(crcx_poly_e p);
        return (p == POLY_CAST) ? CRCX_POLY_CAST : CRCX_POLY_IEEE;
    endfunction

endpackage

// File: rtl/crcx_decode.sv
module crcx_decode
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0] instr_i,
    input  logic        mode64_i,
    output crcx_op_t    op_o
);
    localparam bit WIDE_OK = (XLEN == 64);

    logic [4:0] sel;
    logic       fixed_ok;
    logic       sel_ok;
    logic       size_ok;
    logic       unused_rs1;

    assign sel        = instr_i[24:20];
    assign unused_rs1 = ^instr_i[19:15];

    always_comb begin
        fixed_ok = (instr_i[31:25] == CRCX_FUNCT7) &&
                   (instr_i[14:12] == CRCX_FUNCT3) &&
                   (instr_i[6:0]   == CRCX_OPCODE);
        sel_ok   = sel[4] && !sel[2];
        size_ok  = (sel[1:0] != 2'b11) || (WIDE_OK && mode64_i);

        op_o.legal = fixed_ok && sel_ok && size_ok;
        op_o.poly  = crcx_poly_e'(sel[3]);
        op_o.size  = crcx_size_e'(sel[1:0]);
        op_o.rd    = instr_i[11:7];
    end

endmodule

// File: rtl/crcx_byte_step.sv
module crcx_byte_step
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] x_i,
    input  crcx_poly_e      poly_i,
    output logic [XLEN-1:0] y_o
);
    localparam int BITS = 8;

    logic [XLEN-1:0] poly_w;
    logic [XLEN-1:0] chain [BITS+1];

    assign poly_w   = XLEN'(crcx_poly_value(poly_i));
    assign chain[0] = x_i;

    for (genvar b = 0; b < BITS; b++) begin : g_bit
        assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ poly_w)
                                        :  (chain[b] >> 1);
    end

    assign y_o = chain[BITS];

endmodule

// File: rtl/crcx_seq.sv
module crcx_seq
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  crcx_op_t        op_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic            mode64_i,
    input  logic [XLEN-1:0] step_val_i,
    output logic [XLEN-1:0] work_o,
    output crcx_poly_e      poly_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic [4:0]      rd_idx_o,
    output logic [XLEN-1:0] result_o
);
    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    localparam logic [XLEN-1:0] LOW_MASK = XLEN'(32'hFFFF_FFFF);

    st_e                   state;
    logic [CRCX_CNT_W-1:0] remain;
    logic [XLEN-1:0]       load_val;
    logic                  accept;

    assign accept = start_i && (state == ST_IDLE);
    assign busy_o = (state == ST_RUN);

    always_comb begin
        if (mode64_i && (XLEN == 64)) load_val = rs1_val_i;
        else                          load_val = rs1_val_i & LOW_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remain    <= '0;
            work_o    <= '0;
            poly_o    <= POLY_IEEE;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            rd_idx_o  <= '0;
            result_o  <= '0;
        end else begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (op_i.legal) begin
                            state    <= ST_RUN;
                            remain   <= crcx_steps(op_i.size);
                            work_o   <= load_val;
                            poly_o   <= op_i.poly;
                            rd_idx_o <= op_i.rd;
                        end else begin
                            illegal_o <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    work_o <= step_val_i;
                    remain <= remain - 1'b1;
                    if (remain == CRCX_CNT_W'(1)) begin
                        state    <= ST_IDLE;
                        done_o   <= 1'b1;
                        result_o <= step_val_i;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/crcx_unit.sv
module crcx_unit
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic            mode64_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic [4:0]      rd_idx_o,
    output logic [XLEN-1:0] result_o
);
    crcx_op_t        op;
    crcx_poly_e      poly;
    logic [XLEN-1:0] work;
    logic [XLEN-1:0] step_val;

    crcx_decode #(.XLEN(XLEN)) i_decode (
        .instr_i  (instr_i),
        .mode64_i (mode64_i),
        .op_o     (op)
    );

    crcx_byte_step #(.XLEN(XLEN)) i_step (
        .x_i    (work),
        .poly_i (poly),
        .y_o    (step_val)
    );

    crcx_seq #(.XLEN(XLEN)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .op_i       (op),
        .rs1_val_i  (rs1_val_i),
        .mode64_i   (mode64_i),
        .step_val_i (step_val),
        .work_o     (work),
        .poly_o     (poly),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .illegal_o  (illegal_o),
        .rd_idx_o   (rd_idx_o),
        .result_o   (result_o)
    );

endmodule

// File: rtl/crcx_unit_chk.sv
module crcx_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic [4:0]      rd_idx_o,
    input logic [XLEN-1:0] result_o
);
    logic [3:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)); // R9

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R5

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_len < 4'd8)); // R5

    AST_ILLEGAL_NO_WORK: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!done_o && !busy_o)); // R11

    AST_ILLEGAL_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> ($past(start_i) && !$past(busy_o))); // R10

    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_idx_o)); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rst)) |-> $stable(result_o)); // R9

endmodule

bind crcx_unit crcx_unit_chk #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .rd_idx_o  (rd_idx_o),
    .result_o  (result_o)
);

// File: tb/test_crcx_unit.sv
`timescale 1ns/1ps
module test_crcx_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] rs1_val_i = '0;
    logic            mode64_i = 1'b1;
    logic            busy_o, done_o, illegal_o;
    logic [4:0]      rd_idx_o;
    logic [XLEN-1:0] result_o;

    int vectors = 0;
    int errors  = 0;
    logic [63:0] last_result;

    always #2.5 clk = ~clk;

    crcx_unit #(.XLEN(XLEN)) i_crcx_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
        .rs1_val_i(rs1_val_i), .mode64_i(mode64_i), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o), .rd_idx_o(rd_idx_o),
        .result_o(result_o)
    );

    function automatic logic [31:0] mk(input logic [4:0] sel, input logic [4:0] rd);
        return {7'b0110000, sel, 5'd9, 3'b001, rd, 7'b0010011};
    endfunction

    function automatic bit ref_legal(input logic [31:0] w, input bit m64);
        if (w[31:25] != 7'b0110000 || w[14:12] != 3'b001 || w[6:0] != 7'b0010011) return 0;
        if (!w[24] || w[22]) return 0;
        if (w[21:20] == 2'b11 && !m64) return 0;
        return 1;
    endfunction

    function automatic logic [63:0] ref_crc(input logic [63:0] v, input int n,
                                            input bit cast, input bit m64);
        logic [63:0] x = m64 ? v : {32'd0, v[31:0]};
        logic [63:0] p = cast ? 64'h82F6_3B78 : 64'hEDB8_8320;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                x = x[0] ? ((x >> 1) ^ p) : (x >> 1);
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [63:0] v, input bit m64,
                          input bit intrude);
        bit legal = ref_legal(w, m64);
        int n = 1 << w[21:20];
        logic [63:0] exp = ref_crc(v, n, w[23], m64);
        @(negedge clk);
        instr_i = w; rs1_val_i = v; mode64_i = m64; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (!legal) begin
            chk(illegal_o && !busy_o && !done_o, "R11/R1/R2/R7 illegal pulse",
                {61'd0, illegal_o, busy_o, done_o}, 64'd4);
            @(posedge clk); #1;
            chk(!illegal_o && !done_o && !busy_o, "R11 pulse one cycle",
                {61'd0, illegal_o, busy_o, done_o}, 64'd0);
            return;
        end
        chk(busy_o && !illegal_o && !done_o, "R9 busy after start",
            {61'd0, illegal_o, busy_o, done_o}, 64'd2);
        for (int c = 1; c <= n; c++) begin
            if (intrude && c == 1 && n > 1) begin
                start_i = 1'b1; instr_i = mk(5'b10000, ~w[11:7]); rs1_val_i = ~v;
            end
            @(posedge clk); #1;
            start_i = 1'b0;
            if (intrude)
                chk(!illegal_o, "R10 start while busy", {63'd0, illegal_o}, 64'd0);
            if (c < n) begin
                chk(!done_o && busy_o, "R5 step count early",
                    {62'd0, busy_o, done_o}, 64'd2);
            end else begin
                chk(done_o && !busy_o, "R5/R9 done at last step",
                    {62'd0, busy_o, done_o}, 64'd1);
                chk(result_o == exp, w[23] ? "R4/R6/R8 CRC-32C result" : "R3/R6/R8 CRC-32 result",
                    result_o, exp);
                chk(rd_idx_o == w[11:7], "R9/R10 rd index", {59'd0, rd_idx_o}, {59'd0, w[11:7]});
                last_result = result_o;
            end
        end
        @(posedge clk); #1;
        chk(!done_o && !busy_o, "R9 done one cycle", {62'd0, busy_o, done_o}, 64'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R13 watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(posedge clk);
        #1;
        chk(!busy_o && !done_o && !illegal_o, "R13 reset state",
            {61'd0, illegal_o, busy_o, done_o}, 64'd0);
        @(negedge clk); rst = 1'b0;

        // R12 chained reference vector
        last_result = 64'h34e2_4a2c_d656_50d4;
        for (int k = 0; k < 8; k++)
            run_op(mk({1'b1, k[2], 1'b0, k[1:0]}, 5'd5), last_result, 1'b1, 1'b0);
        chk(last_result == 64'h0000_0000_6816_7e78, "R12 chain value",
            last_result, 64'h6816_7e78);

        // directed corners
        run_op(mk(5'b10011, 5'd1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0); // R7
        run_op(mk(5'b11011, 5'd2), 64'h1, 1'b0, 1'b0);                   // R7
        run_op(mk(5'b10100, 5'd3), 64'h1, 1'b1, 1'b0);                   // R2
        run_op(mk(5'b00000, 5'd3), 64'h1, 1'b1, 1'b0);                   // R2
        run_op(mk(5'b10010, 5'd4) ^ 32'h0000_1000, 64'h1, 1'b1, 1'b0);   // R1
        run_op(mk(5'b10010, 5'd4) ^ 32'h8000_0000, 64'h1, 1'b1, 1'b0);   // R1
        run_op(mk(5'b10010, 5'd4) ^ 32'h0000_0001, 64'h1, 1'b1, 1'b0);   // R1
        run_op(mk(5'b10010, 5'd7), 64'hDEAD_BEEF_0000_0000, 1'b1, 1'b0); // R6 upper fold
        run_op(mk(5'b11010, 5'd8), 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0); // R8
        run_op(mk(5'b11011, 5'd9), 64'hA5A5_0000_FFFF_0001, 1'b1, 1'b1); // R10
        run_op(mk(5'b10001, 5'd10), 64'h0, 1'b1, 1'b0);                  // R6 zero in

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [4:0]  sel = {1'b1, 1'($urandom), 1'b0, 2'($urandom)};
            logic [31:0] w   = mk(sel, 5'($urandom));
            logic [63:0] v   = {$urandom, $urandom};
            bit          m64 = 1'($urandom);
            if ($urandom % 6 == 0) begin
                case ($urandom % 4)
                    0: w[25 + $urandom % 7] ^= 1'b1;
                    1: w[12 + $urandom % 3] ^= 1'b1;
                    2: w[$urandom % 7] ^= 1'b1;
                    default: w[22] = 1'b1;
                endcase
            end
            run_op(w, v, m64, ($urandom % 5) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule